// File: doc/BRIEF.md
# Cartridge 32 KB Program Bank Switch Mapper

This block sits on a cartridge for an 8-bit console, between the CPU bus, the picture-processor (PPU) bus and the cartridge memories. Any CPU write into the upper half of the CPU address space (0x8000–0xFFFF) loads one small control register. That register holds a program bank number and a nametable page bit. The CPU read path uses the bank number to select one whole 32 KB program ROM window. No part of that window is fixed.

On the PPU side, pattern accesses below 0x2000 go unbanked to an 8 KB character RAM, and PPU writes there are stored into it. The page bit drives the nametable RAM address line 10 at all times. This gives single-screen mirroring on either the lower or the upper nametable page. The ROM and RAM arrays themselves live outside the block.

Top module: `prg32_mapper`

## Requirements
- R1: After reset the bank is 0 and the page bit is 0, so `prg_addr` shows bank 0 and `ntram_a10` is 0.
- R2: A rising clock edge with `cpu_wr` high and `cpu_addr[15]` high loads the bank from `cpu_wdata[3:0]`. From the following cycle, `prg_addr[18:15]` shows that bank.
- R3: The same write loads the page from `cpu_wdata[4]`. A 1 drives `ntram_a10` high (upper page) and a 0 drives it low (lower page) from the following cycle.
- R4: `prg_addr` equals {bank, `cpu_addr[14:0]`} for every address in the window. All 32 KB follow the bank.
- R5: A CPU write with `cpu_addr[15]` low changes neither the bank nor the page.
- R6: `prg_oe` is high exactly when `cpu_rd` is high and `cpu_addr[15]` is high. Accesses below 0x8000 are left unclaimed.
- R7: `chr_addr` equals `ppu_addr[12:0]`. `chr_oe` equals `ppu_rd` with `ppu_addr[13]` low. `chr_we` equals `ppu_wr` with `ppu_addr[13]` low.
- R8: `ntram_a10` follows only the latched page bit. It does not depend on any PPU address bit.
- R9: The stored bank is the 4-bit bank field reduced modulo `PRG_BANKS`, so it always lies below `PRG_BANKS`.
- R10: CPU writes never assert `chr_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_rd | input | 1 | CPU read strobe |
| prg_addr | output | 19 | Program ROM byte address |
| prg_oe | output | 1 | Program ROM output enable |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read strobe |
| ppu_wr | input | 1 | PPU write strobe |
| chr_addr | output | 13 | Character RAM address |
| chr_oe | output | 1 | Character RAM output enable |
| chr_we | output | 1 | Character RAM write enable |
| ntram_a10 | output | 1 | Nametable RAM address line 10 (page select) |

## Verification
The bench builds the block with `PRG_BANKS` set to 6, which is not a power of two. This selects the modulo variant of the bank reduction. Bank fields 6 through 15 then fold back into the range, for example 15 becomes 3 and 6 becomes 0, which exercises R9. The power-of-two masking variant is covered only by the default elaboration.

// File: rtl/prg32_pkg.sv
package prg32_pkg;
    localparam int CPU_AW   = 16;
    localparam int PPU_AW   = 14;
    localparam int DATA_W   = 8;
    localparam int WIN_W    = 15;
    localparam int SEL_W    = 4;
    localparam int PAGE_BIT = 4;
    localparam int CHR_AW   = 13;
    localparam int PRG_AW   = SEL_W + WIN_W;

    typedef struct packed {
        logic [SEL_W-1:0] bank;
        logic             page;
    } ctl_regs_t;
endpackage

// File: rtl/prg32_bank_reg.sv
module prg32_bank_reg
    import prg32_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_hit,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  bank,
    output logic              page
);
    localparam bit IS_POW2 = ((PRG_BANKS & (PRG_BANKS - 1)) == 0);

    ctl_regs_t        regs_d, regs_q;
    logic [SEL_W-1:0] sel_red;
    logic             unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:PAGE_BIT+1];

    // Fold the bank field into the populated range at write time
    generate
        if (IS_POW2) begin : g_mask
            assign sel_red = wdata[SEL_W-1:0] & SEL_W'(PRG_BANKS - 1);
        end else begin : g_mod
            assign sel_red = SEL_W'(32'(wdata[SEL_W-1:0]) % 32'(PRG_BANKS));
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        if (wr && win_hit) begin
            regs_d.bank = sel_red;
            regs_d.page = wdata[PAGE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bank = regs_q.bank;
    assign page = regs_q.page;
endmodule

// File: rtl/prg32_prg_map.sv
module prg32_prg_map
    import prg32_pkg::*;
(
    input  logic [SEL_W-1:0]  bank,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_oe
);
    logic win_hit;

    always_comb begin
        win_hit  = cpu_addr[CPU_AW-1];
        prg_addr = {bank, cpu_addr[WIN_W-1:0]};
        prg_oe   = cpu_rd & win_hit;
    end
endmodule

// File: rtl/prg32_chr_path.sv
module prg32_chr_path
    import prg32_pkg::*;
(
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    input  logic              page,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_oe,
    output logic              chr_we,
    output logic              ntram_a10
);
    logic pat_hit;

    always_comb begin
        pat_hit   = ~ppu_addr[PPU_AW-1];
        chr_addr  = ppu_addr[CHR_AW-1:0];
        chr_oe    = ppu_rd & pat_hit;
        chr_we    = ppu_wr & pat_hit;
        ntram_a10 = page;
    end
endmodule

// File: rtl/prg32_mapper.sv
module prg32_mapper
    import prg32_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_oe,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_oe,
    output logic              chr_we,
    output logic              ntram_a10
);
    logic [SEL_W-1:0] bank_q;
    logic             page_q;

    prg32_bank_reg #(.PRG_BANKS(PRG_BANKS)) bank_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_hit (cpu_addr[CPU_AW-1]),
        .wr      (cpu_wr),
        .wdata   (cpu_wdata),
        .bank    (bank_q),
        .page    (page_q)
    );

    prg32_prg_map prg_map_i (
        .bank     (bank_q),
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .prg_addr (prg_addr),
        .prg_oe   (prg_oe)
    );

    prg32_chr_path chr_path_i (
        .ppu_addr  (ppu_addr),
        .ppu_rd    (ppu_rd),
        .ppu_wr    (ppu_wr),
        .page      (page_q),
        .chr_addr  (chr_addr),
        .chr_oe    (chr_oe),
        .chr_we    (chr_we),
        .ntram_a10 (ntram_a10)
    );
endmodule

// File: rtl/prg32_mapper_chk.sv
module prg32_mapper_chk
    import prg32_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [PRG_AW-1:0] prg_addr,
    input logic              prg_oe,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic              ppu_rd,
    input logic              ppu_wr,
    input logic              chr_oe,
    input logic              chr_we,
    input logic              ntram_a10
);
    AST_WR_LOADS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1]) |=>
        (int'(prg_addr[PRG_AW-1:WIN_W]) == int'($past(cpu_wdata[SEL_W-1:0])) % PRG_BANKS)); // R2
    AST_WR_LOADS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1]) |=> (ntram_a10 == $past(cpu_wdata[PAGE_BIT]))); // R3
    AST_LOW_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[CPU_AW-1]) |=>
        ($stable(ntram_a10) && $stable(prg_addr[PRG_AW-1:WIN_W]))); // R5
    AST_PRG_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        prg_oe |-> (cpu_rd && cpu_addr[CPU_AW-1])); // R6
    AST_CHR_WE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        chr_we |-> (ppu_wr && !ppu_addr[PPU_AW-1])); // R7
    AST_CHR_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        chr_oe |-> (ppu_rd && !ppu_addr[PPU_AW-1])); // R7
    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(prg_addr[PRG_AW-1:WIN_W]) < PRG_BANKS); // R9
    AST_CPU_NO_CHR_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !ppu_wr) |-> !chr_we); // R10
endmodule

bind prg32_mapper prg32_mapper_chk #(.PRG_BANKS(PRG_BANKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .prg_addr  (prg_addr),
    .prg_oe    (prg_oe),
    .ppu_addr  (ppu_addr),
    .ppu_rd    (ppu_rd),
    .ppu_wr    (ppu_wr),
    .chr_oe    (chr_oe),
    .chr_we    (chr_we),
    .ntram_a10 (ntram_a10)
);

// File: tb/prg32_mapper_tb_top.sv
`timescale 1ns/1ps
module prg32_mapper_tb_top;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [18:0] prg_addr;
    logic        prg_oe;
    logic [13:0] ppu_addr = '0;
    logic        ppu_rd = 1'b0;
    logic        ppu_wr = 1'b0;
    logic [12:0] chr_addr;
    logic        chr_oe;
    logic        chr_we;
    logic        ntram_a10;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_bank = 0;
    bit exp_page = 1'b0;

    always #2.5 clk = ~clk;

    prg32_mapper #(.PRG_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .prg_addr(prg_addr), .prg_oe(prg_oe),
        .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .chr_addr(chr_addr),
        .chr_oe(chr_oe), .chr_we(chr_we), .ntram_a10(ntram_a10)
    );

    function automatic logic [31:0] f_prg(int bank, logic [15:0] a);
        return {13'd0, 4'(bank), a[14:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a[15]) begin
            exp_bank = int'(d[3:0]) % NB;
            exp_page = d[4];
        end
    endtask

    task automatic cpu_read_chk(logic [15:0] a, bit rd);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = 1'b0;
        #1;
        chk("R4 prg_addr", 32'(prg_addr), f_prg(exp_bank, a));
        chk("R6 prg_oe", 32'(prg_oe), 32'(rd & a[15]));
    endtask

    task automatic ppu_chk(logic [13:0] a, bit rd, bit wr);
        @(negedge clk);
        ppu_addr = a; ppu_rd = rd; ppu_wr = wr;
        #1;
        chk("R7 chr_addr", 32'(chr_addr), 32'(a[12:0]));
        chk("R7 chr_oe", 32'(chr_oe), 32'(rd & ~a[13]));
        chk("R7 chr_we", 32'(chr_we), 32'(wr & ~a[13]));
        chk("R8 ntram_a10", 32'(ntram_a10), 32'(exp_page));
        ppu_rd = 1'b0; ppu_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0707));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 bank", 32'(prg_addr[18:15]), 32'd0);
        chk("R1 page", 32'(ntram_a10), 32'd0);

        // R2 / R3: load bank 5, upper page
        cpu_write(16'h8000, 8'h15);
        #1;
        chk("R2 bank", 32'(prg_addr[18:15]), 32'd5);
        chk("R3 page", 32'(ntram_a10), 32'd1);
        cpu_read_chk(16'hFFFF, 1'b1);
        cpu_read_chk(16'h8000, 1'b1);

        // R9: fold 15 -> 3, 6 -> 0
        cpu_write(16'hFFFF, 8'h0F);
        #1;
        chk("R9 fold15", 32'(prg_addr[18:15]), 32'd3);
        chk("R3 page low", 32'(ntram_a10), 32'd0);
        cpu_write(16'hC123, 8'hE6);
        #1;
        chk("R9 fold6", 32'(prg_addr[18:15]), 32'd0);

        // R5: write below window ignored
        cpu_write(16'hC000, 8'h14);
        cpu_write(16'h7FFF, 8'h03);
        #1;
        chk("R5 bank", 32'(prg_addr[18:15]), 32'd4);
        chk("R5 page", 32'(ntram_a10), 32'd1);

        // R6: unclaimed low reads
        cpu_read_chk(16'h6000, 1'b1);
        cpu_read_chk(16'h9000, 1'b0);

        // R8: page independent of PPU A10/A11
        for (int k = 0; k < 4; k++) ppu_chk(14'h2000 | 14'(k << 10), 1'b1, 1'b0);

        // R10: CPU write with PPU idle never raises chr_we
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_wdata = 8'h01; cpu_wr = 1'b1;
        #1;
        chk("R10 chr_we", 32'(chr_we), 32'd0);
        @(negedge clk);
        cpu_wr = 1'b0;
        exp_bank = 1; exp_page = 1'b0;

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            op = $urandom % 3;
            if (op == 0) begin
                cpu_write(16'($urandom), 8'($urandom));
                #1;
                chk("R2 rand bank", 32'(prg_addr[18:15]), 32'(exp_bank));
                chk("R3 rand page", 32'(ntram_a10), 32'(exp_page));
            end else if (op == 1) begin
                cpu_read_chk(16'($urandom), 1'($urandom));
            end else begin
                ppu_chk(14'($urandom), 1'($urandom), 1'($urandom));
            end
        end
        finish_run();
    end
endmodule